// File: doc/BRIEF.md
# DCO Binary-Search Acquisition Sequencer

This block finds the control word of a digitally controlled oscillator quickly after a new target frequency has been set. It works like a successive-approximation converter. One bit of the control word is tried for each measurement window. An external counter compares the oscillator cycle count over a reference window with the programmed ratio and reports whether the oscillator is fast. The block runs either a full-width search or a search over only the low bank of the word. While it runs, it holds spread spectrum suspended.

When the search ends, the block pulses `done`, drops `busy` and holds the found word on `trial_code`. The tracking loop then takes that word as its starting point, and software may read it back to store as a power-up default. Start requests are one-cycle pulses from initiate bits. The block returns a `start_clear` strobe that clears those bits when a request is accepted. The full-width search can move the oscillator far off frequency for a while, so the clock that feeds it should be parked on a safe source during the search.

Top module: `sar_fastlock`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `ss_suspend` and `start_clear` are 0 and `trial_code` is 0.
- R2: An accepted coarse start makes `trial_code` hold only the top bit (bit 18 of the 19-bit word) on the next cycle, with `busy` at 1.
- R3: An accepted fine start loads `code_in[18:8]` unchanged into the upper bits and 0x80 into the low 8 bits on the next cycle.
- R4: On each `meas_done` while busy, the bit under test is cleared if `dco_fast` is 1 and kept if it is 0. The next lower bit is then set for trial.
- R5: A coarse search ends after 19 measurement strobes and a fine search after 8. `done` is high for exactly one cycle, and in that same cycle `busy` is already 0.
- R6: If the oscillator reads fast exactly when the word exceeds a threshold T, a coarse search ends with `trial_code` equal to T. A fine search ends with the upper bits unchanged and the low byte equal to T's low byte when the upper bits match T. The low byte is 0x00 when the upper bits exceed T's upper bits, and 0xFF when they are below them.
- R7: During a fine search, `trial_code[18:8]` never changes.
- R8: `ss_suspend` is 1 in exactly the cycles in which `busy` is 1.
- R9: Start pulses that arrive while `busy` is 1 are ignored and do not raise `start_clear`. In idle, a start raises `start_clear` in the same cycle and sets `busy` on the next cycle.
- R10: If coarse and fine starts arrive together, the coarse search is run.
- R11: While idle, `meas_done` and `dco_fast` have no effect, and `trial_code` holds the last result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_coarse | input | 1 | Request a full-width search |
| start_fine | input | 1 | Request a low-bank search |
| meas_done | input | 1 | A measurement window has finished |
| dco_fast | input | 1 | The last window counted more cycles than the ratio |
| code_in | input | 19 | Current control word, the source of the upper bits for a fine search |
| trial_code | output | 19 | Control word under trial, or the final result when idle |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| ss_suspend | output | 1 | Hold spread spectrum off |
| start_clear | output | 1 | Clear the initiate bits; the request was accepted |

## Verification
The assertions check every cycle that the done pulse is one cycle wide and falls outside `busy`. They also check that the test bit is one-hot while searching, that an accepted start leads to `busy`, that the upper bits stay still during a fine search, and that the word holds while idle. Only the bench scenarios can show the search arithmetic. Against a threshold oscillator model, they show the resulting word for full-width and low-bank searches at both ends of the range and with mismatched upper bits, and they count the windows used. They also cover start priority and dropped requests during a search.

// File: rtl/sar_lock_pkg.sv
package sar_lock_pkg;

    localparam int CODE_W = 19;
    localparam int FINE_W = 8;
    localparam logic [CODE_W-1:0] TOP_BIT  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] FINE_BIT = CODE_W'(1) << (FINE_W - 1);
    localparam logic [CODE_W-1:0] LOW_BANK = (CODE_W'(1) << FINE_W) - CODE_W'(1);

    typedef enum logic [1:0] {
        SRCH_NONE   = 2'd0,
        SRCH_COARSE = 2'd1,
        SRCH_FINE   = 2'd2
    } srch_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] word;
        logic [CODE_W-1:0] probe;
    } trial_t;

    function automatic trial_t seed_trial(srch_mode_e m, logic [CODE_W-1:0] cur);
        trial_t t;
        if (m == SRCH_FINE) begin
            t.word  = (cur & ~LOW_BANK) | FINE_BIT;
            t.probe = FINE_BIT;
        end else begin
            t.word  = TOP_BIT;
            t.probe = TOP_BIT;
        end
        return t;
    endfunction

endpackage

// File: rtl/sar_bit_update.sv
module sar_bit_update
    import sar_lock_pkg::*;
(
    input  trial_t cur,
    input  logic   fast,
    output trial_t nxt,
    output logic   last
);
    logic [CODE_W-1:0] resolved;

    always_comb begin
        resolved  = fast ? (cur.word & ~cur.probe) : cur.word;
        last      = cur.probe[0];
        nxt.probe = cur.probe >> 1;
        nxt.word  = resolved | (cur.probe >> 1);
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_coarse,
    input  logic       req_fine,
    input  logic       meas_done,
    input  logic       last_bit,
    output logic       accept,
    output srch_mode_e sel_mode,
    output logic       step,
    output logic       busy,
    output logic       done
);
    assign accept   = !busy && (req_coarse || req_fine);
    assign sel_mode = req_coarse ? SRCH_COARSE : (req_fine ? SRCH_FINE : SRCH_NONE);
    assign step     = busy && meas_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= step && last_bit;
            if (accept)
                busy <= 1'b1;
            else if (step && last_bit)
                busy <= 1'b0;
        end
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
endmodule

// File: rtl/sar_fastlock.sv
module sar_fastlock
    import sar_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_coarse,
    input  logic              start_fine,
    input  logic              meas_done,
    input  logic              dco_fast,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] trial_code,
    output logic              busy,
    output logic              done,
    output logic              ss_suspend,
    output logic              start_clear
);
    trial_t     cur_q, nxt;
    logic       accept, step, last_bit, fine_q;
    srch_mode_e sel_mode;

    sar_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_coarse (start_coarse),
        .req_fine   (start_fine),
        .meas_done  (meas_done),
        .last_bit   (last_bit),
        .accept     (accept),
        .sel_mode   (sel_mode),
        .step       (step),
        .busy       (busy),
        .done       (done)
    );

    sar_bit_update u_bit (
        .cur  (cur_q),
        .fast (dco_fast),
        .nxt  (nxt),
        .last (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            fine_q <= 1'b0;
        end else if (accept) begin
            cur_q  <= seed_trial(sel_mode, code_in);
            fine_q <= (sel_mode == SRCH_FINE);
        end else if (step) begin
            cur_q  <= nxt;
        end
    end

    assign trial_code  = cur_q.word;
    assign ss_suspend  = busy;
    assign start_clear = accept;

    p_probe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> $onehot(cur_q.probe));
    p_upper_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && fine_q && $past(busy)) |-> $stable(trial_code[CODE_W-1:FINE_W]));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(accept)) |-> $stable(trial_code));
endmodule

// File: tb/tb_sar_fastlock.sv
module tb_sar_fastlock;
    localparam int CLK_PERIOD = 10;
    localparam int W = 19;
    localparam int NVEC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_coarse = 1'b0, start_fine = 1'b0, meas_done = 1'b0, dco_fast = 1'b0;
    logic [W-1:0] code_in = '0;
    logic [W-1:0] trial_code;
    logic busy, done, ss_suspend, start_clear;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_fastlock dut (
        .clk(clk), .rst(rst), .start_coarse(start_coarse), .start_fine(start_fine),
        .meas_done(meas_done), .dco_fast(dco_fast), .code_in(code_in),
        .trial_code(trial_code), .busy(busy), .done(done),
        .ss_suspend(ss_suspend), .start_clear(start_clear)
    );

    // {fine, code_in, threshold, expected}
    localparam logic [3*W:0] VEC [NVEC] = '{
        {1'b0, 19'h00000, 19'h5A5A5, 19'h5A5A5},
        {1'b0, 19'h00000, 19'h00000, 19'h00000},
        {1'b0, 19'h00000, 19'h7FFFF, 19'h7FFFF},
        {1'b0, 19'h00000, 19'h40000, 19'h40000},
        {1'b0, 19'h00000, 19'h3FFFF, 19'h3FFFF},
        {1'b1, 19'h12345, 19'h123C7, 19'h123C7},
        {1'b1, 19'h12345, 19'h0FFFF, 19'h12300},
        {1'b1, 19'h12345, 19'h7FFFF, 19'h123FF}
    };

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic pulse_start(input bit sc, input bit sf);
        start_coarse = sc; start_fine = sf;
        @(negedge clk);
        start_coarse = 0; start_fine = 0;
    endtask

    // drives strobes until done; returns the window count
    task automatic run_windows(input logic [W-1:0] thr, output int n);
        n = 0;
        while (!done && n < 40) begin
            meas_done = 1; dco_fast = (trial_code > thr);
            @(negedge clk);
            meas_done = 0; dco_fast = 0;
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        check(!busy && !done && !ss_suspend && !start_clear, "R1 flags", {16'b0, busy, done, ss_suspend}, '0);
        check(trial_code == '0, "R1 code", trial_code, '0);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic fine_v; logic [W-1:0] cin, thr, exp_v;
            {fine_v, cin, thr, exp_v} = VEC[i];
            code_in = cin;
            start_coarse = !fine_v; start_fine = fine_v;
            #1 check(start_clear == 1'b1, "R9 accept strobe", {18'b0, start_clear}, 1);
            @(negedge clk);
            start_coarse = 0; start_fine = 0;
            if (fine_v)
                check(trial_code == {cin[W-1:8], 8'h80}, "R3 fine seed", trial_code, {cin[W-1:8], 8'h80});
            else
                check(trial_code == 19'h40000, "R2 coarse seed", trial_code, 19'h40000);
            check(busy && ss_suspend, "R8 suspend while busy", {17'b0, busy, ss_suspend}, 3);
            run_windows(thr, n);
            check(n == (fine_v ? 8 : 19), "R5 window count", W'(n), W'(fine_v ? 8 : 19));
            check(done && !busy && !ss_suspend, "R5 done with busy low", {16'b0, done, busy, ss_suspend}, 4);
            check(trial_code == exp_v, "R6 search result", trial_code, exp_v);
            @(negedge clk);
            check(!done, "R5 done one cycle", {18'b0, done}, 0);
            check(trial_code == exp_v, "R11 result held", trial_code, exp_v);
        end

        // R4: first decision with fast oscillator clears the top bit, sets the next
        code_in = '0;
        pulse_start(1, 0);
        meas_done = 1; dco_fast = 1;
        @(negedge clk);
        meas_done = 0; dco_fast = 0;
        check(trial_code == 19'h20000, "R4 clear on fast", trial_code, 19'h20000);
        meas_done = 1; dco_fast = 0;
        @(negedge clk);
        meas_done = 0;
        check(trial_code == 19'h30000, "R4 keep on slow", trial_code, 19'h30000);

        // R9: starts during a search are dropped
        held = trial_code;
        start_fine = 1; start_coarse = 1;
        #1 check(start_clear == 1'b0, "R9 no strobe while busy", {18'b0, start_clear}, 0);
        @(negedge clk);
        start_fine = 0; start_coarse = 0;
        check(trial_code == held && busy, "R9 busy start ignored", trial_code, held);
        run_windows(19'h3ABCD, n);
        check(n == 17, "R9 search continued", W'(n), W'(17));
        check(trial_code == 19'h3ABCD, "R9 result after ignored start", trial_code, 19'h3ABCD);
        @(negedge clk);

        // R11: strobes while idle do nothing
        held = trial_code;
        repeat (3) begin
            meas_done = 1; dco_fast = 1;
            @(negedge clk);
        end
        meas_done = 0; dco_fast = 0;
        check(trial_code == held && !busy && !done, "R11 idle strobe ignored", trial_code, held);

        // R10: both starts together pick coarse
        code_in = 19'h7FF55;
        pulse_start(1, 1);
        check(trial_code == 19'h40000, "R10 coarse priority", trial_code, 19'h40000);
        run_windows(19'h00123, n);
        check(n == 19 && trial_code == 19'h00123, "R10 coarse run", trial_code, 19'h00123);
        @(negedge clk);

        // R7: fine search with upper bits kept
        code_in = 19'h7FF55;
        pulse_start(0, 1);
        run_windows(19'h7FF0A, n);
        check(trial_code == 19'h7FF0A, "R7 fine upper kept", trial_code, 19'h7FF0A);
        @(negedge clk);

        // R1: reset mid-search
        pulse_start(1, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(!busy && trial_code == '0, "R1 reset mid-search", trial_code, '0);

        finish_run();
    end
endmodule